// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block makes a small on-chip byte array look like a two-wire serial EEPROM to an external bus master. It watches the open-drain clock and data lines, samples them into the system clock domain and finds bus conditions on the sampled copies. It answers only to its own device address. That address is formed from a fixed 4-bit prefix and three strap inputs. The only pin it drives is a data pull-down enable, used for acknowledge bits and for read data.

A master first sends a 16-bit byte pointer, high byte first. It can then do one of three things:
- Send data bytes. These collect in a page buffer that wraps inside a 64-byte page. The array is updated only when a STOP arrives.
- Issue a repeated START and read. This is a random read.
- Read straight away from wherever the pointer is. Every byte sent moves the pointer up by one across the whole address space. A master acknowledge asks for the next byte, and a master not-acknowledge ends the read.

The data moves over the bus wires only, so there is no parallel stream port and no back-pressure path. The strap pins and the enable are plain levels. After a STOP, the master must leave at least one page-length of system clocks (64 by default) before the next START. This gives the page buffer time to drain into the array. A START that arrives while the buffer is draining is ignored.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START, and a rising data line while the clock line is high is a STOP. Either one, at any point (even in the middle of a byte), abandons the current byte, and a START begins a new device-address byte.
- R2: The device byte is acknowledged only when its bits 7..4 equal 1010 and its bits 3..1 equal the strap pins. Bit 0 set to 1 means read. The acknowledge is the data line held low for the whole ninth clock. On a mismatch the data line is never driven until the next START.
- R3: In a write, the two bytes after the device byte load pointer bits 15..8 and then bits 7..0. Each of these bytes is acknowledged.
- R4: Every later data byte in the write is acknowledged and stored at the pointer. The stored bytes reach the array only at the STOP.
- R5: During a write, only pointer bits 5..0 increment. Bytes past the end of a 64-byte page wrap to its start.
- R6: A read returns the array byte at the pointer, most significant bit first, and then increments the full 16-bit pointer. A master acknowledge (data low in the ninth clock) makes the block send the next byte, and this continues across page edges.
- R7: A master not-acknowledge after a read byte makes the block release the data line. It stays released, however many clocks follow, until a START.
- R8: A repeated START clears any data bytes not yet committed and leaves the array unchanged, but keeps the pointer. A dummy write followed by a read therefore reads from the loaded address.
- R9: The block changes its data drive only while the clock line is low. The data line stays constant through every high phase of a read bit.
- R10: While reset is held and after it is released, the data drive is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 3 | Device address select pins, compared with address bits 3..1 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pulls the data line low when 1 |

## Verification
Two things can collide inside one byte frame. A bus condition can arrive while the bit shifter is still counting: the rising clock edge that begins a START is also seen as a data-bit edge. The bench provokes this by sending four bits, issuing a fresh START, and then doing a complete random read. That read returns the right byte only if the framing was restarted cleanly. A second collision is between the drain of the page buffer and the bus: a page write whose bytes wrap is followed at once by a sequential read. Each returned byte is compared with what the wrap rule predicts, and the data line is sampled twice in every high phase to confirm that it stays steady.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int PTR_W = 16;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } bus_st_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end
endmodule

// File: rtl/i2cm_pagebuf.sv
module i2cm_pagebuf #(
  parameter int PAGE_AW = 6,
  parameter int PTR_W   = 16,
  parameter int MEM_AW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PAGE_AW-1:0]       wr_idx,
  input  logic [7:0]               wr_data,
  input  logic [PTR_W-PAGE_AW-1:0] wr_page,
  input  logic                     clear,
  input  logic                     commit,
  output logic                     busy,
  output logic                     mem_we,
  output logic [MEM_AW-1:0]        mem_addr,
  output logic [7:0]               mem_wdata
);
  localparam int PAGE = 1 << PAGE_AW;

  logic [7:0]               data_q [PAGE];
  logic [PAGE-1:0]          vld;
  logic [PTR_W-PAGE_AW-1:0] page_q;
  logic [PAGE_AW-1:0]       scan;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      page_q <= '0;
      scan   <= '0;
      busy   <= 1'b0;
    end else if (busy) begin
      vld[scan] <= 1'b0;
      scan      <= scan + 1'b1;
      if (scan == {PAGE_AW{1'b1}}) busy <= 1'b0;
    end else if (clear) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
      page_q      <= wr_page;
    end else if (commit && |vld) begin
      busy <= 1'b1;
      scan <= '0;
    end
  end

  assign mem_we    = busy & vld[scan];
  assign mem_addr  = MEM_AW'({page_q, scan});
  assign mem_wdata = data_q[scan];

  // R4
  drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scan == {PAGE_AW{1'b1}}) |=> (vld == '0 && !busy));

  // R4
  no_fill_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && busy));
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter logic [3:0] DEV_ID  = 4'b1010,
  parameter int         PAGE_AW = 6,
  parameter int         MEM_AW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               strap,
  input  logic                     scl_lvl,
  input  logic                     sda_lvl,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_evt,
  input  logic                     stop_evt,
  input  logic                     busy,
  input  logic [7:0]               rd_data,
  output logic [MEM_AW-1:0]        rd_addr,
  output logic                     buf_we,
  output logic [PAGE_AW-1:0]       buf_idx,
  output logic [7:0]               buf_data,
  output logic [PTR_W-PAGE_AW-1:0] buf_page,
  output logic                     buf_clear,
  output logic                     commit,
  output logic                     sda_oe
);
  bus_st_t          st;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [1:0]       byte_idx;
  logic             rw, mack;
  logic [PTR_W-1:0] ptr;

  logic rx_done, dev_match, go_start;
  assign go_start  = start_evt & ~busy;
  assign rx_done   = (st == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign dev_match = (shreg[7:4] == DEV_ID) && (shreg[3:1] == strap);

  assign buf_we    = rx_done && (byte_idx == 2'd3);
  assign buf_idx   = ptr[PAGE_AW-1:0];
  assign buf_data  = shreg;
  assign buf_page  = ptr[PTR_W-1:PAGE_AW];
  assign buf_clear = go_start;
  assign commit    = stop_evt & ~busy;
  assign rd_addr   = MEM_AW'(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
    end else if (go_start) begin
      st       <= ST_RX;
      bitcnt   <= '0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (rx_done) begin
            bitcnt <= '0;
            sda_oe <= 1'b1;
            st     <= ST_RX_ACK;
            case (byte_idx)
              2'd0: begin
                rw <= shreg[0];
                if (!dev_match) begin
                  sda_oe <= 1'b0;
                  st     <= ST_IDLE;
                end
              end
              2'd1: ptr[15:8] <= shreg;
              2'd2: ptr[7:0]  <= shreg;
              default: ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (byte_idx == 2'd0 && rw) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
              if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_TX_ACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack <= ~sda_lvl;
          if (scl_fall) begin
            if (mack) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              st     <= ST_TX;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  start_reframes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> (st == ST_RX && bitcnt == 4'd0 && byte_idx == 2'd0));

  // R7
  nack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe);

  // R9
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2cm_pkg::*;
#(
  parameter logic [3:0] DEV_ID  = 4'b1010,
  parameter int         MEM_AW  = 8,
  parameter int         PAGE_AW = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, buf_we, buf_clear, commit, mem_we;
  logic [7:0]               rd_data, buf_data, mem_wdata;
  logic [MEM_AW-1:0]        rd_addr, mem_addr;
  logic [PAGE_AW-1:0]       buf_idx;
  logic [PTR_W-PAGE_AW-1:0] buf_page;

  i2cm_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cm_ctrl #(.DEV_ID(DEV_ID), .PAGE_AW(PAGE_AW), .MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strap(strap_i), .scl_lvl(scl_lvl),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .busy(busy),
    .rd_data(rd_data), .rd_addr(rd_addr), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_data(buf_data), .buf_page(buf_page),
    .buf_clear(buf_clear), .commit(commit), .sda_oe(sda_oe_o)
  );

  i2cm_pagebuf #(.PAGE_AW(PAGE_AW), .PTR_W(PTR_W), .MEM_AW(MEM_AW)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_idx(buf_idx),
    .wr_data(buf_data), .wr_page(buf_page), .clear(buf_clear),
    .commit(commit), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  i2cm_mem #(.AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic oe;
  wire  sda_line = sda_m & ~oe;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe_o(oe)
  );

  localparam int Q = 10;
  localparam logic [7:0] DEV_W = 8'hAA; // 1010, strap 101, write
  localparam logic [7:0] DEV_R = 8'hAB; // 1010, strap 101, read
  // {pointer, data}
  localparam logic [23:0] VEC [8] = '{
    24'h0000_5A, 24'h0001_C3, 24'h003E_11, 24'h003F_22,
    24'h0040_33, 24'h0041_44, 24'h1280_9E, 24'hFFFF_01
  };

  int n_chk = 0, n_bad = 0, edge_err = 0;
  logic ack;
  logic [7:0] d;

  task automatic waitc(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_c();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(2*Q);
    sda_m = 1'b0; waitc(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic stop_c();
    waitc(Q); sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(2*Q);
    sda_m = 1'b1; waitc(150);
  endtask

  task automatic byte_w(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      waitc(Q); sda_m = b[i]; waitc(Q);
      scl_m = 1'b1; waitc(2*Q); scl_m = 1'b0;
    end
    waitc(Q); sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q); a = ~sda_line; waitc(Q);
    scl_m = 1'b0;
  endtask

  task automatic byte_r(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; waitc(2*Q);
      scl_m = 1'b1; waitc(Q); v[i] = sda_line; waitc(Q);
      if (sda_line !== v[i]) edge_err++;
      scl_m = 1'b0;
    end
    waitc(Q); sda_m = ~mack; waitc(Q);
    scl_m = 1'b1; waitc(2*Q); scl_m = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    start_c();
    byte_w(DEV_W, ack);   chk("R2 device ack", 16'(ack), 16'd1);
    byte_w(a[15:8], ack); chk("R3 high ack", 16'(ack), 16'd1);
    byte_w(a[7:0], ack);  chk("R3 low ack", 16'(ack), 16'd1);
  endtask

  task automatic rd_at(input logic [15:0] a, output logic [7:0] v);
    set_ptr(a);
    start_c();
    byte_w(DEV_R, ack); chk("R8 read device ack", 16'(ack), 16'd1);
    byte_r(1'b0, v);
    stop_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    waitc(5);
    chk("R10 drive in reset", 16'(oe), 16'd0);
    rst_n = 1'b1;
    waitc(20);
    chk("R10 drive after reset", 16'(oe), 16'd0);

    // vector walk: single-byte write then random read (R4, R6, R8)
    for (int k = 0; k < 8; k++) begin
      set_ptr(VEC[k][23:8]);
      byte_w(VEC[k][7:0], ack); chk("R4 data ack", 16'(ack), 16'd1);
      stop_c();
      rd_at(VEC[k][23:8], d);
      chk("R4 R6 readback", 16'(d), 16'(VEC[k][7:0]));
    end

    // R2 wrong strap and wrong prefix are ignored
    start_c();
    byte_w(8'hA4, ack); chk("R2 strap mismatch nack", 16'(ack), 16'd0);
    byte_w(8'h00, ack); chk("R2 stays silent", 16'(ack), 16'd0);
    stop_c();
    start_c();
    byte_w(8'hBA, ack); chk("R2 prefix mismatch nack", 16'(ack), 16'd0);
    stop_c();

    // R1 START in the middle of a byte restarts framing
    start_c();
    for (int i = 0; i < 4; i++) begin
      waitc(Q); sda_m = i[0]; waitc(Q);
      scl_m = 1'b1; waitc(2*Q); scl_m = 1'b0;
    end
    rd_at(16'h0001, d);
    chk("R1 reframe after mid-byte START", 16'(d), 16'h00C3);

    // R5 page write wraps inside the page
    set_ptr(16'h003E);
    byte_w(8'hA1, ack); byte_w(8'hA2, ack);
    byte_w(8'hA3, ack); byte_w(8'hA4, ack);
    chk("R5 wrap data ack", 16'(ack), 16'd1);
    stop_c();

    // R6 sequential read crossing the page edge, R9 steady during high
    edge_err = 0;
    set_ptr(16'h003E);
    start_c();
    byte_w(DEV_R, ack);
    byte_r(1'b1, d); chk("R6 seq byte0", 16'(d), 16'h00A1);
    byte_r(1'b1, d); chk("R6 seq byte1", 16'(d), 16'h00A2);
    byte_r(1'b1, d); chk("R5 R6 seq byte2 not overwritten", 16'(d), 16'h0033);
    byte_r(1'b0, d); chk("R6 seq byte3", 16'(d), 16'h0044);
    // R7 after NACK the line stays released
    byte_r(1'b0, d); chk("R7 released after nack", 16'(d), 16'h00FF);
    stop_c();
    chk("R9 data stable while clock high", 16'(edge_err), 16'd0);
    rd_at(16'h0000, d); chk("R5 wrapped byte at 0", 16'(d), 16'h00A3);
    rd_at(16'h0001, d); chk("R5 wrapped byte at 1", 16'(d), 16'h00A4);

    // R8 repeated START discards pending data, keeps pointer
    set_ptr(16'h0000);
    byte_w(8'h77, ack);
    start_c();
    byte_w(DEV_R, ack);
    byte_r(1'b0, d); chk("R8 pointer kept past pending byte", 16'(d), 16'h00A4);
    stop_c();
    rd_at(16'h0000, d); chk("R8 pending byte discarded", 16'(d), 16'h00A3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule